// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block models the device side of a parallel NOR flash command interface as clocked, synthesizable logic. A host drives chip-enable, write-enable and output-enable strobes (all active low), an address and a 16-bit data word. The block decodes multi-cycle unlock sequences into program, sector-erase, fast-program (bypass), suspend, resume and reset commands. It owns a small word array held in registers.

Program and erase run for a parameterised number of clock cycles. During that time a ready output is low, and reads return a status word in place of array data. The status word carries a data-polling bit and a toggle bit. Erase and program can be suspended so that the host can reach other sectors. A per-sector protection input and a low-supply input block writes. A synchronous device-reset input aborts whatever is running.

A write cycle is registered on the clock edge where write-enable is seen high after having been low, with chip-enable low. The address and data are latched on that edge.

Top module: `nfl_cmd_top`

## Requirements
- R1: After power reset (rst_n low) every array word reads FFFFh and rdy is 1.
- R2: The sequence AAh@555h, 55h@2AAh, A0h@555h, then D@A programs word A. After PROG_CYC cycles the word holds its old value ANDed with D.
- R3: Any unlock or command cycle whose address or low data byte does not match the expected one returns the sequencer to read mode. F0h outside the program-data cycle does the same. No operation starts in either case.
- R4: AAh@555h, 55h@2AAh, 20h@555h enters bypass mode. In bypass mode, A0h followed by D@A programs with two cycles. 90h followed by 00h leaves bypass mode.
- R5: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 30h@S erases the sector holding S. The sector is address bits [7:6]. After ERASE_CYC cycles every word of that sector reads FFFFh and the other sectors are unchanged.
- R6: While an operation runs, a read at any address returns a status word. Bit 7 is the complement of bit 7 of the programmed data, or 0 for an erase. Bit 6 inverts after each read start, meaning an output-enable falling edge with chip-enable low. All other bits are 0.
- R7: rdy goes low on the clock after the cycle that starts an operation. It stays low for exactly the operation's cycle count, excluding suspended time.
- R8: B0h during an erase suspends it and rdy returns to 1. Reads of other sectors return array data; reads of the erasing sector return status with bit 7 = 0. Programs to other sectors run, programs to the erasing sector are dropped, and 30h resumes the remaining erase cycles.
- R9: B0h during a program suspends it and rdy returns to 1. Reads of other sectors return array data. Every write other than 30h is ignored, and 30h resumes the program.
- R10: A set bit prot[s] prevents program and erase in sector s.
- R11: While vlow is 1 every write cycle is ignored.
- R12: dev_rst_n low for one clock aborts any operation without changing the array. It clears suspend and bypass state and returns to read mode.
- R13: rdata is 0 whenever ce_n or oe_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power reset, active low; clears the array to all ones |
| dev_rst_n | input | 1 | Synchronous device reset, active low; aborts operations |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; a write cycle is registered when it is seen rising |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data or status word |
| rdy | output | 1 | 1 when no operation is running |
| vlow | input | 1 | Low-supply indication; blocks all writes |
| prot | input | 2**SECT_AW | Per-sector protection bits |

## Verification
The hardest states to reach are the nested ones. One is an erase suspended with a program running in another sector underneath it. The other is a program suspended partway through its count. Both depend on a suspend write landing inside a busy window that lasts only a few cycles. The bench therefore issues the suspend write immediately after the starting cycle, and then keeps reads, dropped programs and the resume inside that window. A behavioural model in the bench tracks the remaining busy count, the suspend flags and the toggle bit on every clock, so a resume that loses or repeats cycles shows up as a rdy mismatch.

// File: rtl/nfl_pkg.sv
package nfl_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PGM,
    SQ_ERS1,
    SQ_ERS2,
    SQ_ERS3,
    SQ_BYPX
  } seq_e;

  localparam logic [7:0] K_UNL_A  = 8'hAA;
  localparam logic [7:0] K_UNL_B  = 8'h55;
  localparam logic [7:0] K_PROG   = 8'hA0;
  localparam logic [7:0] K_ERASE  = 8'h80;
  localparam logic [7:0] K_SECT   = 8'h30;
  localparam logic [7:0] K_BYP    = 8'h20;
  localparam logic [7:0] K_BYPX1  = 8'h90;
  localparam logic [7:0] K_BYPX2  = 8'h00;
  localparam logic [7:0] K_SUSP   = 8'hB0;
  localparam logic [7:0] K_RESUME = 8'h30;
  localparam logic [7:0] K_RST    = 8'hF0;

  localparam logic [10:0] KA_FIRST  = 11'h555;
  localparam logic [10:0] KA_SECOND = 11'h2AA;

endpackage

// File: rtl/nfl_bus_sync.sv
module nfl_bus_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic wr_stb,
  output logic rd_start
);

  logic we_q, oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      we_q <= we_n;
      oe_q <= oe_n;
    end
  end

  assign wr_stb   = !we_q && we_n && !ce_n;
  assign rd_start = oe_q && !oe_n && !ce_n;

endmodule

// File: rtl/nfl_busy_timer.sv
module nfl_busy_timer #(
  parameter int CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);

  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start || run;
    cnt_d  = start ? CW'(CYC) : cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == CW'(1));

endmodule

// File: rtl/nfl_array.sv
module nfl_array #(
  parameter int ARR_AW  = 8,
  parameter int DATA_W  = 16,
  parameter int SECT_AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_we,
  input  logic [ARR_AW-1:0] pg_addr,
  input  logic [DATA_W-1:0] pg_data,
  input  logic              er_we,
  input  logic [SECT_AW-1:0] er_sect,
  input  logic [ARR_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int WORDS = 1 << ARR_AW;
  localparam int WPS   = 1 << (ARR_AW - SECT_AW);

  logic [DATA_W-1:0] mem_q [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (er_we && ((i / WPS) == int'(er_sect)))
          mem_q[i] <= '1;
        else if (pg_we && (int'(pg_addr) == i))
          mem_q[i] <= mem_q[i] & pg_data;
      end
    end
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/nfl_cmd_seq.sv
module nfl_cmd_seq
  import nfl_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int ARR_AW  = 8,
  parameter int DATA_W  = 16,
  parameter int SECT_AW = 2,
  localparam int NSECT  = 1 << SECT_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dev_rst_n,
  input  logic               wr_stb,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_data,
  input  logic               vlow,
  input  logic [NSECT-1:0]   prot,
  input  logic               pg_done,
  input  logic               er_done,
  output logic               pg_start,
  output logic               er_start,
  output logic               pg_run,
  output logic               er_run,
  output logic               pg_susp,
  output logic               er_susp,
  output logic [ARR_AW-1:0]  pg_addr,
  output logic [DATA_W-1:0]  pg_data,
  output logic [SECT_AW-1:0] er_sect,
  output seq_e               seq_st
);

  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(KA_FIRST);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(KA_SECOND);

  seq_e               seq_d;
  logic               byp_q, byp_d;
  logic               pg_run_d, er_run_d, pg_susp_d, er_susp_d;
  logic [7:0]         d8;
  logic               at_a1, at_a2;
  logic [SECT_AW-1:0] wr_sect;
  logic               pg_ok;

  assign d8      = bus_data[7:0];
  assign at_a1   = (bus_addr == A1);
  assign at_a2   = (bus_addr == A2);
  assign wr_sect = bus_addr[ARR_AW-1 -: SECT_AW];
  assign pg_ok   = !prot[wr_sect] && !(er_susp && (wr_sect == er_sect));

  always_comb begin
    seq_d     = seq_st;
    byp_d     = byp_q;
    pg_run_d  = pg_run;
    er_run_d  = er_run;
    pg_susp_d = pg_susp;
    er_susp_d = er_susp;
    pg_start  = 1'b0;
    er_start  = 1'b0;

    if (pg_done) pg_run_d = 1'b0;
    if (er_done) er_run_d = 1'b0;

    if (wr_stb && !vlow) begin
      if (pg_run) begin
        if (d8 == K_SUSP && !er_susp && !pg_done) begin
          pg_run_d  = 1'b0;
          pg_susp_d = 1'b1;
        end
      end else if (er_run) begin
        if (d8 == K_SUSP && !er_done) begin
          er_run_d  = 1'b0;
          er_susp_d = 1'b1;
        end
      end else if (pg_susp) begin
        if (d8 == K_RESUME) begin
          pg_run_d  = 1'b1;
          pg_susp_d = 1'b0;
        end
      end else if (er_susp && seq_st == SQ_IDLE && d8 == K_RESUME) begin
        er_run_d  = 1'b1;
        er_susp_d = 1'b0;
      end else if (seq_st != SQ_PGM && d8 == K_RST) begin
        seq_d = SQ_IDLE;
      end else begin
        seq_d = SQ_IDLE;
        unique case (seq_st)
          SQ_IDLE: begin
            if (byp_q) begin
              if (d8 == K_PROG)       seq_d = SQ_PGM;
              else if (d8 == K_BYPX1) seq_d = SQ_BYPX;
            end else if (d8 == K_UNL_A && at_a1) begin
              seq_d = SQ_UNL1;
            end
          end
          SQ_UNL1: if (d8 == K_UNL_B && at_a2) seq_d = SQ_UNL2;
          SQ_UNL2: begin
            if (at_a1 && d8 == K_PROG)                  seq_d = SQ_PGM;
            else if (at_a1 && d8 == K_ERASE && !er_susp) seq_d = SQ_ERS1;
            else if (at_a1 && d8 == K_BYP && !er_susp)   byp_d = 1'b1;
          end
          SQ_PGM: begin
            if (pg_ok) begin
              pg_start = 1'b1;
              pg_run_d = 1'b1;
            end
          end
          SQ_ERS1: if (d8 == K_UNL_A && at_a1) seq_d = SQ_ERS2;
          SQ_ERS2: if (d8 == K_UNL_B && at_a2) seq_d = SQ_ERS3;
          SQ_ERS3: begin
            if (d8 == K_SECT && !prot[wr_sect]) begin
              er_start = 1'b1;
              er_run_d = 1'b1;
            end
          end
          SQ_BYPX: if (d8 == K_BYPX2) byp_d = 1'b0;
          default: seq_d = SQ_IDLE;
        endcase
      end
    end

    if (!dev_rst_n) begin
      seq_d     = SQ_IDLE;
      byp_d     = 1'b0;
      pg_run_d  = 1'b0;
      er_run_d  = 1'b0;
      pg_susp_d = 1'b0;
      er_susp_d = 1'b0;
      pg_start  = 1'b0;
      er_start  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_st  <= SQ_IDLE;
      byp_q   <= 1'b0;
      pg_run  <= 1'b0;
      er_run  <= 1'b0;
      pg_susp <= 1'b0;
      er_susp <= 1'b0;
    end else begin
      seq_st  <= seq_d;
      byp_q   <= byp_d;
      pg_run  <= pg_run_d;
      er_run  <= er_run_d;
      pg_susp <= pg_susp_d;
      er_susp <= er_susp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_addr <= '0;
      pg_data <= '0;
    end else if (pg_start) begin
      pg_addr <= bus_addr[ARR_AW-1:0];
      pg_data <= bus_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) er_sect <= '0;
    else if (er_start) er_sect <= wr_sect;
  end

endmodule

// File: rtl/nfl_cmd_top.sv
module nfl_cmd_top
  import nfl_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 16,
  parameter int ARR_AW    = 8,
  parameter int SECT_AW   = 2,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 30
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dev_rst_n,
  input  logic                     ce_n,
  input  logic                     we_n,
  input  logic                     oe_n,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata,
  output logic                     rdy,
  input  logic                     vlow,
  input  logic [(1<<SECT_AW)-1:0]  prot
);

  logic               wr_stb, rd_start;
  logic               pg_start, er_start, pg_done, er_done;
  logic               pg_run, er_run, pg_susp, er_susp;
  logic [ARR_AW-1:0]  pg_addr;
  logic [DATA_W-1:0]  pg_data;
  logic [SECT_AW-1:0] er_sect;
  seq_e               seq_st;
  logic [DATA_W-1:0]  arr_data;
  logic               pg_we, er_we;
  logic               tog_q;
  logic               busy;
  logic [SECT_AW-1:0] rd_sect, pg_sect;
  logic [DATA_W-1:0]  stat;
  logic               show_stat, poll_bit;

  nfl_bus_sync u_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .wr_stb(wr_stb), .rd_start(rd_start)
  );

  nfl_cmd_seq #(
    .ADDR_W(ADDR_W), .ARR_AW(ARR_AW), .DATA_W(DATA_W), .SECT_AW(SECT_AW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .dev_rst_n(dev_rst_n), .wr_stb(wr_stb),
    .bus_addr(addr), .bus_data(wdata), .vlow(vlow), .prot(prot),
    .pg_done(pg_done), .er_done(er_done),
    .pg_start(pg_start), .er_start(er_start),
    .pg_run(pg_run), .er_run(er_run), .pg_susp(pg_susp), .er_susp(er_susp),
    .pg_addr(pg_addr), .pg_data(pg_data), .er_sect(er_sect), .seq_st(seq_st)
  );

  nfl_busy_timer #(.CYC(PROG_CYC)) u_pg_tmr (
    .clk(clk), .rst_n(rst_n), .start(pg_start), .run(pg_run), .done(pg_done)
  );

  nfl_busy_timer #(.CYC(ERASE_CYC)) u_er_tmr (
    .clk(clk), .rst_n(rst_n), .start(er_start), .run(er_run), .done(er_done)
  );

  assign pg_we = pg_done && dev_rst_n;
  assign er_we = er_done && dev_rst_n;

  nfl_array #(.ARR_AW(ARR_AW), .DATA_W(DATA_W), .SECT_AW(SECT_AW)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .pg_we(pg_we), .pg_addr(pg_addr), .pg_data(pg_data),
    .er_we(er_we), .er_sect(er_sect),
    .rd_addr(addr[ARR_AW-1:0]), .rd_data(arr_data)
  );

  assign busy = pg_run || er_run;
  assign rdy  = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else if (rd_start && busy) tog_q <= !tog_q;
  end

  assign rd_sect = addr[ARR_AW-1 -: SECT_AW];
  assign pg_sect = pg_addr[ARR_AW-1 -: SECT_AW];

  always_comb begin
    show_stat = 1'b0;
    poll_bit  = 1'b0;
    if (pg_run) begin
      show_stat = 1'b1;
      poll_bit  = !pg_data[7];
    end else if (er_run) begin
      show_stat = 1'b1;
    end else if (pg_susp && rd_sect == pg_sect) begin
      show_stat = 1'b1;
      poll_bit  = !pg_data[7];
    end else if (er_susp && rd_sect == er_sect) begin
      show_stat = 1'b1;
    end
    stat    = '0;
    stat[7] = poll_bit;
    stat[6] = tog_q;
    if (ce_n || oe_n) rdata = '0;
    else if (show_stat) rdata = stat;
    else rdata = arr_data;
  end

endmodule

// File: rtl/nfl_chk.sv
module nfl_chk
  import nfl_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dev_rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vlow,
  input logic              wr_stb,
  input logic              rd_start,
  input logic              pg_start,
  input logic              er_start,
  input logic              pg_run,
  input logic              pg_susp,
  input logic              er_susp,
  input logic              tog_q,
  input logic              rdy,
  input logic [DATA_W-1:0] rdata,
  input seq_e              seq_st
);

  // R7
  start_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rst_n && (pg_start || er_start)) |=> !rdy);

  // R11
  vlow_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && vlow && rdy && !pg_susp && dev_rst_n) |=> (rdy && $stable(seq_st)));

  // R12
  dev_reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rst_n |=> (rdy && !pg_susp && !er_susp && seq_st == SQ_IDLE));

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !rdy) |=> (tog_q != $past(tog_q)));

  // R8
  erase_susp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (er_susp && !pg_run) |-> rdy);

  // R9
  prog_susp_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pg_susp |-> rdy);

  // R13
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || oe_n) |-> (rdata == '0));

endmodule

bind nfl_cmd_top nfl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dev_rst_n(dev_rst_n), .ce_n(ce_n), .oe_n(oe_n),
  .vlow(vlow), .wr_stb(wr_stb), .rd_start(rd_start), .pg_start(pg_start),
  .er_start(er_start), .pg_run(pg_run), .pg_susp(pg_susp), .er_susp(er_susp),
  .tog_q(tog_q), .rdy(rdy), .rdata(rdata), .seq_st(seq_st)
);

// File: tb/tb_nfl_cmd_top.sv
`timescale 1ns/1ps
module tb_nfl_cmd_top;

  localparam int PROG_CYC  = 8;
  localparam int ERASE_CYC = 30;

  logic        clk = 1'b0;
  logic        rst_n, dev_rst_n, ce_n, we_n, oe_n, vlow;
  logic [10:0] addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        rdy;
  logic [3:0]  prot;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  nfl_cmd_top #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .dev_rst_n(dev_rst_n), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .wdata(wdata), .rdata(rdata), .rdy(rdy),
    .vlow(vlow), .prot(prot)
  );

  // ---------------- behavioural reference ----------------
  int unsigned m_mem [256];
  int  m_seq;          // 0 idle 1 u1 2 u2 3 data 4 e1 5 e2 6 e3 7 bypass-exit
  bit  m_byp, m_prun, m_erun, m_ps, m_es, m_tog, m_weq, m_oeq;
  int  m_pcnt, m_ecnt, m_paddr, m_esect;
  int unsigned m_pdat;

  task automatic model_reset();
    for (int i = 0; i < 256; i++) m_mem[i] = 16'hFFFF;
    m_seq = 0; m_byp = 0; m_prun = 0; m_erun = 0; m_ps = 0; m_es = 0;
    m_tog = 0; m_weq = 1; m_oeq = 1; m_pcnt = 0; m_ecnt = 0;
    m_paddr = 0; m_pdat = 0; m_esect = 0;
  endtask

  task automatic model_step();
    bit wr, rs, was_p, was_e, pdone, edone;
    int a, d8, s;
    wr = !m_weq && we_n && !ce_n;
    rs = m_oeq && !oe_n && !ce_n;
    if (rs && (m_prun || m_erun)) m_tog = !m_tog;
    m_weq = we_n; m_oeq = oe_n;
    if (!dev_rst_n) begin
      m_seq = 0; m_byp = 0; m_prun = 0; m_erun = 0; m_ps = 0; m_es = 0;
      return;
    end
    was_p = m_prun; was_e = m_erun;
    pdone = m_prun && m_pcnt == 1;
    edone = m_erun && m_ecnt == 1;
    if (m_prun) m_pcnt--;
    if (m_erun) m_ecnt--;
    if (pdone) begin m_mem[m_paddr] &= m_pdat; m_prun = 0; end
    if (edone) begin
      for (int i = 0; i < 64; i++) m_mem[m_esect*64 + i] = 16'hFFFF;
      m_erun = 0;
    end
    if (!wr || vlow) return;
    a = int'(addr); d8 = int'(wdata[7:0]); s = (a >> 6) & 3;
    if (was_p) begin
      if (d8 == 'hB0 && !m_es && !pdone) begin m_prun = 0; m_ps = 1; end
    end else if (was_e) begin
      if (d8 == 'hB0 && !edone) begin m_erun = 0; m_es = 1; end
    end else if (m_ps) begin
      if (d8 == 'h30) begin m_prun = 1; m_ps = 0; end
    end else if (m_es && m_seq == 0 && d8 == 'h30) begin
      m_erun = 1; m_es = 0;
    end else if (m_seq != 3 && d8 == 'hF0) begin
      m_seq = 0;
    end else begin
      int nxt;
      nxt = 0;
      case (m_seq)
        0: if (m_byp) begin
             if (d8 == 'hA0) nxt = 3; else if (d8 == 'h90) nxt = 7;
           end else if (d8 == 'hAA && a == 'h555) nxt = 1;
        1: if (d8 == 'h55 && a == 'h2AA) nxt = 2;
        2: if (a == 'h555 && d8 == 'hA0) nxt = 3;
           else if (a == 'h555 && d8 == 'h80 && !m_es) nxt = 4;
           else if (a == 'h555 && d8 == 'h20 && !m_es) m_byp = 1;
        3: if (!prot[s] && !(m_es && s == m_esect)) begin
             m_prun = 1; m_pcnt = PROG_CYC; m_paddr = a & 'hFF; m_pdat = wdata;
           end
        4: if (d8 == 'hAA && a == 'h555) nxt = 5;
        5: if (d8 == 'h55 && a == 'h2AA) nxt = 6;
        6: if (d8 == 'h30 && !prot[s]) begin
             m_erun = 1; m_ecnt = ERASE_CYC; m_esect = s;
           end
        7: if (d8 == 'h00) m_byp = 0;
        default: nxt = 0;
      endcase
      m_seq = nxt;
    end
  endtask

  function automatic logic [15:0] model_rd();
    int a, s;
    logic [15:0] st;
    if (ce_n || oe_n) return 16'h0;
    a = int'(addr) & 'hFF; s = a >> 6;
    st = 16'h0; st[6] = m_tog;
    if (m_prun) begin st[7] = !m_pdat[7]; return st; end
    if (m_erun) return st;
    if (m_ps && s == (m_paddr >> 6)) begin st[7] = !m_pdat[7]; return st; end
    if (m_es && s == m_esect) return st;
    return 16'(m_mem[a]);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) model_reset();
    else model_step();
  end

  // lockstep comparison every cycle (R6 R7 R13)
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rdy !== !(m_prun || m_erun) || rdata !== model_rd()) begin
        errors++;
        $display("FAIL R7 R6 lockstep t=%0t rdy=%b rdata=%h expected rdy=%b rdata=%h",
                 $time, rdy, rdata, !(m_prun || m_erun), model_rd());
      end
    end
  end

  // watchdog
  initial begin
    wait (cycles > 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [10:0] a, input logic [15:0] d);
    @(posedge clk); #2; ce_n = 0; addr = a; wdata = d; we_n = 0;
    @(posedge clk); #2; we_n = 1;
    @(posedge clk); #2; ce_n = 1;
  endtask

  task automatic bus_rd(input logic [10:0] a, output logic [15:0] d);
    @(posedge clk); #2; ce_n = 0; oe_n = 0; addr = a;
    @(negedge clk); d = rdata;
    @(posedge clk); #2; oe_n = 1; ce_n = 1;
  endtask

  task automatic unlock();
    bus_wr(11'h555, 16'h00AA);
    bus_wr(11'h2AA, 16'h0055);
  endtask

  task automatic prog(input logic [10:0] a, input logic [15:0] d);
    unlock();
    bus_wr(11'h555, 16'h00A0);
    bus_wr(a, d);
  endtask

  task automatic erase(input logic [10:0] a);
    unlock();
    bus_wr(11'h555, 16'h0080);
    unlock();
    bus_wr(a, 16'h0030);
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (rdy) break;
    end
  endtask

  logic [15:0] v, v2;

  initial begin
    rst_n = 0; dev_rst_n = 1; ce_n = 1; we_n = 1; oe_n = 1; vlow = 0;
    addr = '0; wdata = '0; prot = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;

    // R1 reset state
    @(negedge clk); chk("R1 rdy after reset", 16'(rdy), 16'h1);
    bus_rd(11'h000, v); chk("R1 word 000h", v, 16'hFFFF);
    bus_rd(11'h0C5, v); chk("R1 word 0C5h", v, 16'hFFFF);

    // R13 idle bus
    @(posedge clk); #2; ce_n = 0; addr = 11'h000;
    @(negedge clk); chk("R13 oe_n high gives zero", rdata, 16'h0);
    @(posedge clk); #2; ce_n = 1;

    // R2 / R6 / R7 normal program
    prog(11'h010, 16'h1234);
    @(negedge clk); chk("R7 rdy low while programming", 16'(rdy), 16'h0);
    bus_rd(11'h0A0, v); bus_rd(11'h0A0, v2);
    chk("R6 poll bit during program", v & 16'hFFBF, 16'h0080);
    chk("R6 toggle bit differs", (v ^ v2) & 16'h0040, 16'h0040);
    wait_ready();
    bus_rd(11'h010, v); chk("R2 programmed word", v, 16'h1234);
    prog(11'h010, 16'hFF0F); wait_ready();
    bus_rd(11'h010, v); chk("R2 program ANDs", v, 16'h1204);

    // R3 wrong unlock and F0 abort
    bus_wr(11'h555, 16'h00AA); bus_wr(11'h2AB, 16'h0055);
    bus_wr(11'h555, 16'h00A0); bus_wr(11'h011, 16'h0000);
    @(negedge clk); chk("R3 no start after bad unlock", 16'(rdy), 16'h1);
    bus_rd(11'h011, v); chk("R3 word unchanged", v, 16'hFFFF);
    bus_wr(11'h555, 16'h00AA); bus_wr(11'h555, 16'h00F0);
    bus_wr(11'h2AA, 16'h0055); bus_wr(11'h555, 16'h00A0); bus_wr(11'h012, 16'h0000);
    bus_rd(11'h012, v); chk("R3 F0 returns to read mode", v, 16'hFFFF);

    // R4 bypass
    unlock(); bus_wr(11'h555, 16'h0020);
    bus_wr(11'h000, 16'h00A0); bus_wr(11'h020, 16'h5555); wait_ready();
    bus_rd(11'h020, v); chk("R4 bypass program", v, 16'h5555);
    bus_wr(11'h000, 16'h0090); bus_wr(11'h000, 16'h0000);
    bus_wr(11'h000, 16'h00A0); bus_wr(11'h021, 16'h0000); wait_ready();
    bus_rd(11'h021, v); chk("R4 bypass exited", v, 16'hFFFF);

    // R5 erase
    prog(11'h050, 16'hABCD); wait_ready();
    erase(11'h005);
    bus_rd(11'h0C0, v); chk("R6 erase status", v & 16'hFFBF, 16'h0000);
    wait_ready();
    bus_rd(11'h010, v); chk("R5 erased word", v, 16'hFFFF);
    bus_rd(11'h020, v); chk("R5 erased word 2", v, 16'hFFFF);
    bus_rd(11'h050, v); chk("R5 other sector kept", v, 16'hABCD);

    // R8 erase suspend
    prog(11'h000, 16'h0000); wait_ready();
    erase(11'h000);
    bus_wr(11'h000, 16'h00B0);
    @(negedge clk); chk("R8 rdy after erase suspend", 16'(rdy), 16'h1);
    bus_rd(11'h050, v); chk("R8 other sector readable", v, 16'hABCD);
    bus_rd(11'h000, v); chk("R8 target sector status", v & 16'hFFBF, 16'h0000);
    prog(11'h090, 16'h00FF); wait_ready();
    bus_rd(11'h090, v); chk("R8 program in other sector", v, 16'h00FF);
    prog(11'h001, 16'h0000);
    @(negedge clk); chk("R8 program in erasing sector dropped", 16'(rdy), 16'h1);
    bus_wr(11'h000, 16'h0030);
    @(negedge clk); chk("R8 resume busy", 16'(rdy), 16'h0);
    wait_ready();
    bus_rd(11'h000, v); chk("R8 erase completed", v, 16'hFFFF);
    bus_rd(11'h001, v); chk("R8 dropped program", v, 16'hFFFF);

    // R9 program suspend
    prog(11'h0C0, 16'h0F0F);
    bus_wr(11'h000, 16'h00B0);
    @(negedge clk); chk("R9 rdy after program suspend", 16'(rdy), 16'h1);
    bus_rd(11'h090, v); chk("R9 other sector readable", v, 16'h00FF);
    bus_rd(11'h0C1, v); chk("R9 target sector status", v & 16'hFFBF, 16'h0080);
    bus_wr(11'h555, 16'h00AA);
    @(negedge clk); chk("R9 writes ignored", 16'(rdy), 16'h1);
    bus_wr(11'h000, 16'h0030); wait_ready();
    bus_rd(11'h0C0, v); chk("R9 program completed", v, 16'h0F0F);

    // R10 protection
    prot = 4'b0010;
    prog(11'h050, 16'h0000);
    @(negedge clk); chk("R10 protected program", 16'(rdy), 16'h1);
    erase(11'h050);
    @(negedge clk); chk("R10 protected erase", 16'(rdy), 16'h1);
    bus_rd(11'h050, v); chk("R10 word kept", v, 16'hABCD);
    prot = 4'b0000;

    // R11 low supply
    vlow = 1;
    prog(11'h0D0, 16'h0000);
    @(negedge clk); chk("R11 vlow no start", 16'(rdy), 16'h1);
    vlow = 0;
    bus_rd(11'h0D0, v); chk("R11 word kept", v, 16'hFFFF);

    // R12 device reset
    prog(11'h0E0, 16'h0000);
    @(posedge clk); #2; dev_rst_n = 0;
    @(posedge clk); #2; dev_rst_n = 1;
    @(negedge clk); chk("R12 rdy after abort", 16'(rdy), 16'h1);
    bus_rd(11'h0E0, v); chk("R12 aborted word", v, 16'hFFFF);
    unlock(); bus_wr(11'h555, 16'h0020);
    @(posedge clk); #2; dev_rst_n = 0;
    @(posedge clk); #2; dev_rst_n = 1;
    bus_wr(11'h000, 16'h00A0); bus_wr(11'h0E1, 16'h0000); wait_ready();
    bus_rd(11'h0E1, v); chk("R12 bypass cleared", v, 16'hFFFF);

    repeat (4) @(posedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule